// File: doc/BRIEF.md
# Prioritized banked interrupt controller

This block collects up to 64 level-sensitive interrupt requests from peripherals, in banks of 32. It gates each request with a per-source enable and steers each one to one of two processor interrupt lines: a normal line and a fast line. A per-source route bit selects the line. A table of priority slots lets software name which peripheral each slot stands for. A status word then reports, with a valid flag, the peripheral named by the lowest-numbered valid slot whose source is active and routed to the normal line.

All state is reached through a plain 32-bit register port. The port has a byte address, a write strobe, write data and combinational read data. Register writes take effect at the clock edge. Every output and every read view follows the request inputs in the same cycle. A wake output tells the power logic that something wants attention. A control bit picks whether any raw request counts for wake, or only enabled ones.

Top module: `prio_intc`

## Requirements
- R1: After reset, every enable bit, route bit, slot entry and the control bit is 0. With no requests, `irq_o`, `fiq_o` and `wake_o` are 0 and every register reads 0.
- R2: A source is active when its request input and its enable bit are both 1. The raw view reads the request inputs unchanged, regardless of enables. It sits at byte offset 0x10 for sources 0–31 and at 0xAC for sources 32–63, with bit n for source n mod 32.
- R3: Route bit 0 sends a source to the normal line. `irq_o` is the OR of active normal-routed sources. The normal pending view at 0x00 (sources 0–31) and 0x9C (sources 32–63) reads that set.
- R4: Route bit 1 sends a source to the fast line. `fiq_o` is the OR of active fast-routed sources. The fast pending view sits at 0x0C and 0xA8.
- R5: The enable registers at 0x04 and 0xA0 and the route registers at 0x08 and 0xA4 are fully writable. A read returns the last value written.
- R6: Priority slot s sits at 0x1C + 4s for s < 32 and at 0xB0 + 4(s − 32) for s ≥ 32. Write bit 31 is the valid flag and bits 5:0 the peripheral ID. A read returns those fields with all other bits 0.
- R7: The status word at 0x18 reads bit 31 = 1 and bits 30:16 = ID when some valid slot names an active normal-routed source. The ID comes from the lowest-numbered such slot. Invalid slots and slots naming inactive or fast-routed sources are skipped.
- R8: When no slot qualifies, the status word reads 0.
- R9: The control register at 0x14 holds one bit (bit 0). With it clear, `wake_o` is the OR of all request inputs. With it set, `wake_o` is the OR of active sources.
- R10: Writes to the read-only views (0x00, 0x0C, 0x10, 0x18, 0x9C, 0xA8, 0xAC) and to unmapped addresses change nothing. Addresses above 0x12C read 0. Address bits 1:0 are ignored.
- R11: Requests are level-sensitive. Dropping a request or clearing its enable bit removes it from every output in the same cycle, with no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Synchronized level requests, bit n = source n |
| bus_addr_i | input | 9 | Register byte address |
| bus_we_i | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| wake_o | output | 1 | Wake indication |

## Verification
Two things can land in the same cycle here: a register write that changes an enable, route or slot entry, and a change on the request inputs. In that cycle the outputs must reflect the new requests against the old register contents, and in the next cycle the new contents. The bench provokes this with directed writes that clear an enable while another source rises. A long random phase then mixes request changes, writes to every address and reads. A behavioural model, with arrays and a loop over slots, predicts both lines, wake and the read data at every falling edge.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    // Register word indices (byte address >> 2)
    localparam int BANK_REGS        = 5;
    localparam int CTRL_WORD        = 5;
    localparam int STATUS_WORD      = 6;
    localparam int BANK1_BASE_WORD  = 39;
    localparam int SLOT_LO_BASE     = 7;
    localparam int SLOT_HI_BASE     = 44;
    localparam int SLOTS_PER_GROUP  = 32;
    localparam int LAST_MAPPED_WORD = SLOT_HI_BASE + SLOTS_PER_GROUP - 1;
    localparam int STATUS_ID_W      = 15;
    localparam int STATUS_ID_LSB    = 16;

    typedef enum logic [2:0] {
        BR_NORMAL = 3'd0,
        BR_ENABLE = 3'd1,
        BR_ROUTE  = 3'd2,
        BR_FAST   = 3'd3,
        BR_RAW    = 3'd4
    } bank_reg_e;

    function automatic int bank_base(input int b);
        return (b == 0) ? 0 : BANK1_BASE_WORD;
    endfunction

    function automatic int slot_word(input int s);
        return (s < SLOTS_PER_GROUP) ? (SLOT_LO_BASE + s)
                                     : (SLOT_HI_BASE + s - SLOTS_PER_GROUP);
    endfunction

endpackage

// File: rtl/prio_intc_bank.sv
module prio_intc_bank
    import prio_intc_pkg::*;
#(
    parameter int BANK_W    = 32,
    parameter int WORD_W    = 7,
    parameter int BASE_WORD = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              we_i,
    input  logic [BANK_W-1:0] wdata_i,
    output logic [BANK_W-1:0] active_o,
    output logic [BANK_W-1:0] normal_o,
    output logic [BANK_W-1:0] fast_o,
    output logic [BANK_W-1:0] rdata_o
);

    logic [BANK_W-1:0] enable_q;
    logic [BANK_W-1:0] route_q;
    logic [WORD_W-1:0] rel;
    logic              in_bank;
    bank_reg_e         field;

    always_comb begin
        rel     = word_i - WORD_W'(BASE_WORD);
        in_bank = (word_i >= WORD_W'(BASE_WORD)) && (rel < WORD_W'(BANK_REGS));
        field   = bank_reg_e'(rel[2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            route_q  <= '0;
        end else if (we_i && in_bank) begin
            if (field == BR_ENABLE) enable_q <= wdata_i;
            if (field == BR_ROUTE)  route_q  <= wdata_i;
        end
    end

    always_comb begin
        active_o = src_i & enable_q;
        normal_o = active_o & ~route_q;
        fast_o   = active_o & route_q;
    end

    always_comb begin
        rdata_o = '0;
        if (in_bank) begin
            case (field)
                BR_NORMAL: rdata_o = normal_o;
                BR_ENABLE: rdata_o = enable_q;
                BR_ROUTE:  rdata_o = route_q;
                BR_FAST:   rdata_o = fast_o;
                BR_RAW:    rdata_o = src_i;
                default:   rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_intc_slots.sv
module prio_intc_slots
    import prio_intc_pkg::*;
#(
    parameter int NUM_SLOTS = 64,
    parameter int ID_W      = 6,
    parameter int WORD_W    = 7,
    parameter int DW        = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    word_i,
    input  logic                 we_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [NUM_SLOTS-1:0] normal_i,
    output logic                 win_valid_o,
    output logic [ID_W-1:0]      win_id_o,
    output logic [DW-1:0]        rdata_o
);

    logic [NUM_SLOTS-1:0] valid_q;
    logic [ID_W-1:0]      id_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] sel;
    logic                 unused_wdata;

    assign unused_wdata = ^wdata_i[DW-2:ID_W];

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign sel[s] = (word_i == WORD_W'(slot_word(s)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[s] <= 1'b0;
                id_q[s]    <= '0;
            end else if (we_i && sel[s]) begin
                valid_q[s] <= wdata_i[DW-1];
                id_q[s]    <= wdata_i[ID_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (sel[s]) begin
                rdata_o[DW-1]     = valid_q[s];
                rdata_o[ID_W-1:0] = id_q[s];
            end
        end
    end

    // Scan from the highest slot down so the lowest qualifying slot wins.
    always_comb begin
        win_valid_o = 1'b0;
        win_id_o    = '0;
        for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
            if (valid_q[s] && normal_i[id_q[s]]) begin
                win_valid_o = 1'b1;
                win_id_o    = id_q[s];
            end
        end
    end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] src_i,
    input  logic [ADDR_W-1:0]           bus_addr_i,
    input  logic                        bus_we_i,
    input  logic [BANK_W-1:0]           bus_wdata_i,
    output logic [BANK_W-1:0]           bus_rdata_o,
    output logic                        irq_o,
    output logic                        fiq_o,
    output logic                        wake_o
);

    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int ID_W    = $clog2(NUM_SRC);
    localparam int WORD_W  = ADDR_W - 2;

    logic [WORD_W-1:0]  word;
    logic               unused_addr;
    logic [NUM_SRC-1:0] active;
    logic [NUM_SRC-1:0] normal_set;
    logic [NUM_SRC-1:0] fast_set;
    logic [BANK_W-1:0]  bank_rd [NUM_BANKS];
    logic [BANK_W-1:0]  slot_rd;
    logic               ctrl_q;
    logic               hp_valid;
    logic [ID_W-1:0]    hp_id;

    assign word        = bus_addr_i[ADDR_W-1:2];
    assign unused_addr = ^bus_addr_i[1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        prio_intc_bank #(
            .BANK_W   (BANK_W),
            .WORD_W   (WORD_W),
            .BASE_WORD(bank_base(b))
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[b*BANK_W +: BANK_W]),
            .word_i  (word),
            .we_i    (bus_we_i),
            .wdata_i (bus_wdata_i),
            .active_o(active[b*BANK_W +: BANK_W]),
            .normal_o(normal_set[b*BANK_W +: BANK_W]),
            .fast_o  (fast_set[b*BANK_W +: BANK_W]),
            .rdata_o (bank_rd[b])
        );
    end

    prio_intc_slots #(
        .NUM_SLOTS(NUM_SRC),
        .ID_W     (ID_W),
        .WORD_W   (WORD_W),
        .DW       (BANK_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (word),
        .we_i       (bus_we_i),
        .wdata_i    (bus_wdata_i),
        .normal_i   (normal_set),
        .win_valid_o(hp_valid),
        .win_id_o   (hp_id),
        .rdata_o    (slot_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 1'b0;
        else if (bus_we_i && word == WORD_W'(CTRL_WORD))
            ctrl_q <= bus_wdata_i[0];
    end

    always_comb begin
        irq_o  = |normal_set;
        fiq_o  = |fast_set;
        wake_o = ctrl_q ? (|active) : (|src_i);
    end

    always_comb begin
        bus_rdata_o = slot_rd;
        for (int b = 0; b < NUM_BANKS; b++)
            bus_rdata_o = bus_rdata_o | bank_rd[b];
        if (word == WORD_W'(CTRL_WORD))
            bus_rdata_o[0] = ctrl_q;
        if (word == WORD_W'(STATUS_WORD)) begin
            bus_rdata_o[BANK_W-1] = hp_valid;
            bus_rdata_o[STATUS_ID_LSB +: STATUS_ID_W] = STATUS_ID_W'(hp_id);
        end
    end

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
    import prio_intc_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 6,
    parameter int WORD_W  = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_i,
    input logic [WORD_W-1:0]  word,
    input logic               we,
    input logic [31:0]        wdata,
    input logic [31:0]        rdata,
    input logic               irq,
    input logic               fiq,
    input logic               wake,
    input logic               ctrl,
    input logic               hp_valid,
    input logic [ID_W-1:0]    hp_id
);

    assert_quiet_without_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == '0) |-> (!irq && !fiq && !wake));

    assert_winner_needs_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hp_valid |-> irq);

    assert_no_winner_zero_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hp_valid |-> (hp_id == '0));

    assert_wake_on_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl && (|src_i)) |-> wake);

    assert_wake_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl && wake) |-> (irq || fiq));

    assert_enable_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && word == WORD_W'(1)) |=> (word != WORD_W'(1) || rdata == $past(wdata)));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (word > WORD_W'(LAST_MAPPED_WORD)) |-> (rdata == '0));

endmodule

bind prio_intc prio_intc_chk #(
    .NUM_SRC(NUM_SRC),
    .ID_W   (ID_W),
    .WORD_W (WORD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .word    (word),
    .we      (bus_we_i),
    .wdata   (bus_wdata_i),
    .rdata   (bus_rdata_o),
    .irq     (irq_o),
    .fiq     (fiq_o),
    .wake    (wake_o),
    .ctrl    (ctrl_q),
    .hp_valid(hp_valid),
    .hp_id   (hp_id)
);

// File: tb/prio_intc_test.sv
module prio_intc_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] src;
    logic [8:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    always #10 clk = ~clk;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr),
        .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .wake_o(wake)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit chk_on = 0;

    // Behavioural model state
    logic [63:0] m_en    = '0;
    logic [63:0] m_route = '0;
    bit          m_ctrl  = 0;
    bit          m_sv [64];
    int          m_sid[64];

    function automatic logic [31:0] m_status();
        logic [63:0] nset;
        nset = src & m_en & ~m_route;
        for (int s = 0; s < 64; s++)
            if (m_sv[s] && nset[m_sid[s]])
                return {1'b1, 15'(m_sid[s]), 16'h0000};
        return 32'h0;
    endfunction

    function automatic logic [31:0] m_read(input int w);
        logic [63:0] act;
        act = src & m_en;
        case (w)
            0:  return act[31:0] & ~m_route[31:0];
            1:  return m_en[31:0];
            2:  return m_route[31:0];
            3:  return act[31:0] & m_route[31:0];
            4:  return src[31:0];
            5:  return {31'h0, m_ctrl};
            6:  return m_status();
            39: return act[63:32] & ~m_route[63:32];
            40: return m_en[63:32];
            41: return m_route[63:32];
            42: return act[63:32] & m_route[63:32];
            43: return src[63:32];
            default: begin
                if (w >= 7 && w <= 38)
                    return {m_sv[w-7], 25'h0, 6'(m_sid[w-7])};
                if (w >= 44 && w <= 75)
                    return {m_sv[w-12], 25'h0, 6'(m_sid[w-12])};
                return 32'h0;
            end
        endcase
    endfunction

    function automatic string req_of(input int w);
        if (w == 0 || w == 39) return "R3";
        if (w == 3 || w == 42) return "R4";
        if (w == 4 || w == 43) return "R2";
        if (w == 1 || w == 2 || w == 40 || w == 41) return "R5";
        if (w == 5) return "R9";
        if (w == 6) return "R7";
        if ((w >= 7 && w <= 38) || (w >= 44 && w <= 75)) return "R6";
        return "R10";
    endfunction

    function automatic void m_write(input int w, input logic [31:0] d);
        case (w)
            1:  m_en[31:0]     = d;
            2:  m_route[31:0]  = d;
            5:  m_ctrl         = d[0];
            40: m_en[63:32]    = d;
            41: m_route[63:32] = d;
            default: begin
                if (w >= 7 && w <= 38) begin
                    m_sv[w-7] = d[31]; m_sid[w-7] = int'(d[5:0]);
                end else if (w >= 44 && w <= 75) begin
                    m_sv[w-12] = d[31]; m_sid[w-12] = int'(d[5:0]);
                end
            end
        endcase
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", r, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            chk("R3", 32'(irq),  32'(|(src & m_en & ~m_route)));
            chk("R4", 32'(fiq),  32'(|(src & m_en & m_route)));
            chk("R9", 32'(wake), 32'(m_ctrl ? |(src & m_en) : |src));
            chk(req_of(int'(addr[8:2])), rdata, m_read(int'(addr[8:2])));
        end
    end

    task automatic wr(input int w, input logic [31:0] d);
        @(posedge clk); #2;
        addr = 9'(w * 4) | 9'($urandom_range(0, 3)); we = 1'b1; wdata = d;
        @(posedge clk); #1;
        m_write(w, d); we = 1'b0;
    endtask

    task automatic wr_src(input int w, input logic [31:0] d, input logic [63:0] v);
        @(posedge clk); #2;
        addr = 9'(w * 4); we = 1'b1; wdata = d; src = v;
        @(posedge clk); #1;
        m_write(w, d); we = 1'b0;
    endtask

    task automatic rd(input int w);
        @(posedge clk); #2;
        addr = 9'(w * 4);
    endtask

    task automatic put_src(input logic [63:0] v);
        @(posedge clk); #2;
        src = v;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        for (int s = 0; s < 64; s++) begin m_sv[s] = 0; m_sid[s] = 0; end
        rst_n = 1'b0; src = '0; addr = '0; we = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk_on = 1;

        // R1: reset state
        @(negedge clk);
        chk("R1", {29'h0, irq, fiq, wake}, 32'h0);
        rd(1);  @(negedge clk); chk("R1", rdata, 32'h0);
        rd(41); @(negedge clk); chk("R1", rdata, 32'h0);
        for (int w = 0; w < 90; w++) rd(w);

        // R5: enables and routes, both banks
        wr(1, 32'hFFFF_00F0);
        wr(40, 32'h8000_0001);
        wr(2, 32'h0000_00C0);
        wr(41, 32'h0000_0001);
        rd(40); @(negedge clk); chk("R5", rdata, 32'h8000_0001);

        // R2/R3/R4: mixed request pattern
        put_src(64'h8000_0001_0000_00F1);
        foreach (m_en[i]) if (i < 1) ;
        rd(0);  @(negedge clk); chk("R3", rdata, 32'h0000_0030);
        rd(3);  @(negedge clk); chk("R4", rdata, 32'h0000_00C0);
        rd(43); @(negedge clk); chk("R2", rdata, 32'h8000_0001);
        rd(42); @(negedge clk); chk("R4", rdata, 32'h0000_0001);
        rd(39); @(negedge clk); chk("R3", rdata, 32'h8000_0000);

        // R8: no valid slot
        rd(6); @(negedge clk); chk("R8", rdata, 32'h0);

        // R6/R7: slot table
        wr(7, 32'h0000_0005);            // slot 0, invalid
        rd(6); @(negedge clk); chk("R7", rdata, 32'h0);
        wr(10, 32'h8000_0006);           // slot 3 -> fast-routed source 6
        rd(6); @(negedge clk); chk("R7", rdata, 32'h0);
        wr(17, 32'h8000_003F);           // slot 10 -> source 63
        rd(6); @(negedge clk); chk("R7", rdata, 32'h803F_0000);
        wr(44, 32'h8000_0004);           // slot 32 -> source 4, lower priority
        rd(6); @(negedge clk); chk("R7", rdata, 32'h803F_0000);
        wr(7, 32'h8000_0004);            // slot 0 -> source 4
        rd(6); @(negedge clk); chk("R7", rdata, 32'h8004_0000);
        rd(44); @(negedge clk); chk("R6", rdata, 32'h8000_0004);
        wr(75, 32'hFFFF_FFEA);
        rd(75); @(negedge clk); chk("R6", rdata, 32'h8000_002A);

        // R9: wake selection
        put_src(64'h1);
        @(negedge clk); chk("R9", 32'(wake), 32'h1);
        wr(5, 32'h1);
        @(negedge clk); chk("R9", 32'(wake), 32'h0);
        put_src(64'h10);
        @(negedge clk); chk("R9", 32'(wake), 32'h1);
        wr(5, 32'h0);

        // R10: read-only and unmapped writes
        wr(0, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF);
        wr(43, 32'hFFFF_FFFF); wr(80, 32'hFFFF_FFFF); wr(127, 32'h1234_5678);
        rd(1);  @(negedge clk); chk("R10", rdata, 32'hFFFF_00F0);
        rd(80); @(negedge clk); chk("R10", rdata, 32'h0);

        // R11: enable cleared while another source rises, same cycle
        put_src(64'h10);
        wr_src(1, 32'h0000_0000, 64'h110);
        @(negedge clk); chk("R11", 32'(irq), 32'h0);
        wr(1, 32'h0000_0100);
        @(negedge clk); chk("R11", 32'(irq), 32'h1);
        put_src(64'h0);
        @(negedge clk); chk("R11", 32'(irq), 32'h0);

        // Random mix, compared every cycle
        for (int i = 0; i < 1500; i++) begin
            case ($urandom_range(0, 3))
                0: put_src({$urandom(), $urandom()} & {$urandom(), $urandom()});
                1: wr(int'($urandom_range(0, 80)), $urandom());
                2: wr(int'($urandom_range(0, 6)), $urandom());
                default: rd(int'($urandom_range(0, 80)));
            endcase
        end

        @(negedge clk);
        finish_run();
    end

endmodule